// File: doc/BRIEF.md
# Chained Configuration Boot Sequencer

This block runs on the controlling device of a chain of identical processing devices. After power-on, or when a restart is requested, it reads configuration bytes from a byte-wide external ROM. It presents each ROM address, waits a fixed number of clocks for the data to settle, and then pulses a data strobe for one cycle. The ROM is split into 128-byte blocks, one per device. The seven low address bits select a byte within a block. A 4-bit block counter supplies the four upper address bits.

Bytes 0 to 73 of block 0 belong to the controlling device itself, and the block stores them in an internal register file. The low nibble of register 0 gives the number of extra devices in the chain. When the block counter reaches that number, the current block becomes the last one. In cascaded operation, the sequencer waits after every strobe for a return signal from the end of the chain before it moves on. A stand-alone device reads block 0 only. An active-low load flag stays low for the whole sequence and rises once byte 73 of the last block has been written. A done flag then stays high until the next restart.

Top module: `boot_ldr_top`

## Requirements
- R1: The mode input is sampled in the first cycle after reset. If it is high, the sequencer starts at block 0, byte 0 in the next cycle, with load_n_o low. If it is low, the block stays idle: load_n_o stays high, no strobe is issued, and a restart request is ignored while the mode input is low.
- R2: Each address is held on rom_addr_o for ROM_WAIT cycles (default 2) with no strobe. strobe_o is then high for exactly one cycle on the same address.
- R3: rom_blk_o carries the 4-bit block counter. In a block that is not the last, byte 127 is followed by byte 0 of the next block.
- R4: When single_i is low, the address is held after each strobe until chain_ret_i is found high. chain_ret_i is sampled from the cycle after the strobe onward, and the next address appears in the cycle after it is found high. When single_i is high, the next address follows the strobe directly.
- R5: When single_i is low, the last block is the one whose number equals bits 3:0 of byte 0 of block 0 (0 means a single block). When single_i is high, only block 0 is read, whatever that field holds.
- R6: In the last block, reading stops after byte 73 is strobed, so a full load issues exactly last_block*128 + 74 strobes. load_n_o rises in the cycle after that final strobe (single) or after the return is seen (cascaded).
- R7: Byte k of block 0, for k from 0 to 73, is stored in register k and can be read on cfg_rdata_o by placing k on cfg_raddr_i. Bytes from other blocks are not stored. Indices 74 to 127 read as 0.
- R8: done_o is high from the end of a load until a restart is accepted. A restart (retrigger_i high with eprom_mode_i high) is accepted only while idle or done, and is ignored during a load.
- R9: While reset is held, load_n_o=1, strobe_o=0, done_o=0, and the address and block outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eprom_mode_i | input | 1 | 1 = load from ROM, 0 = externally hosted (stay idle) |
| single_i | input | 1 | 1 = stand-alone device, block 0 only and no return wait |
| retrigger_i | input | 1 | Request to start a new load |
| chain_ret_i | input | 1 | Return from the last device, ends each write |
| rom_data_i | input | 8 | ROM data byte |
| rom_addr_o | output | 7 | Byte address within the block |
| rom_blk_o | output | 4 | Block number (upper ROM address bits) |
| strobe_o | output | 1 | One-cycle data strobe |
| load_n_o | output | 1 | Active-low load in progress |
| done_o | output | 1 | Load finished |
| cfg_raddr_i | input | 7 | Register file read index |
| cfg_rdata_o | output | 8 | Register file read data |

## Verification
The assertions assume that single_i and eprom_mode_i stay steady while load_n_o is low. In particular, the return-wait and block-zero checks read single_i as it stood at the strobe. The stimulus changes these inputs only while reset is held or while the block is idle or done. Restart pulses and varying return patterns are applied during loads, so the return wait and the ignored restart are exercised in the middle of a sequence.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    localparam int DATA_W  = 8;
    localparam int BYTE_AW = 7;
    localparam int BLK_W   = 4;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_ADDR,
        ST_STRB,
        ST_RET,
        ST_DONE
    } ldr_state_e;

    typedef struct packed {
        logic [BLK_W-1:0]   blk;
        logic [BYTE_AW-1:0] byt;
    } rom_ptr_t;

    function automatic logic byte_at_end(logic [BYTE_AW-1:0] b);
        return &b;
    endfunction

    function automatic logic state_loading(ldr_state_e s);
        return (s == ST_ADDR) || (s == ST_STRB) || (s == ST_RET);
    endfunction

endpackage

// File: rtl/ldr_ptr_cnt.sv
module ldr_ptr_cnt
    import ldr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     adv,
    output rom_ptr_t ptr
);
    localparam logic [BLK_W-1:0]   BLK_ONE  = 1;
    localparam logic [BYTE_AW-1:0] BYTE_ONE = 1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (adv) begin
            if (byte_at_end(ptr.byt)) begin
                ptr.byt <= '0;
                ptr.blk <= ptr.blk + BLK_ONE;
            end else begin
                ptr.byt <= ptr.byt + BYTE_ONE;
            end
        end
    end
endmodule

// File: rtl/ldr_cfg_regs.sv
module ldr_cfg_regs
    import ldr_pkg::*;
#(
    parameter int NUM_REGS = 74
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [BYTE_AW-1:0] widx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [BYTE_AW-1:0] ridx,
    output logic [DATA_W-1:0]  rdata,
    output logic [BLK_W-1:0]   dev_cnt
);
    localparam logic [BYTE_AW-1:0] LAST_IDX = BYTE_AW'(NUM_REGS - 1);

    logic [DATA_W-1:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (we && (widx <= LAST_IDX)) begin
            regs[widx] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (ridx <= LAST_IDX) rdata = regs[ridx];
    end

    assign dev_cnt = regs[0][BLK_W-1:0];
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq
    import ldr_pkg::*;
#(
    parameter int ROM_WAIT = 2,
    parameter int NUM_REGS = 74
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eprom_mode,
    input  logic             single,
    input  logic             retrig,
    input  logic             chain_ret,
    input  rom_ptr_t         ptr,
    input  logic [BLK_W-1:0] dev_cnt,
    output logic             ptr_clr,
    output logic             ptr_adv,
    output logic             strobe,
    output logic             load_n,
    output logic             done,
    output logic             wr_en
);
    localparam int WC_W = (ROM_WAIT > 1) ? $clog2(ROM_WAIT) : 1;
    localparam logic [WC_W-1:0]    WAIT_END = WC_W'(ROM_WAIT - 1);
    localparam logic [WC_W-1:0]    WC_ONE   = 1;
    localparam logic [BYTE_AW-1:0] LAST_REG = BYTE_AW'(NUM_REGS - 1);

    ldr_state_e       state, nxt;
    logic [WC_W-1:0]  wcnt;
    logic             last_blk, fin, go, step_ok;

    always_comb begin
        last_blk = single ? (ptr.blk == '0) : (ptr.blk == dev_cnt);
        fin      = last_blk && (ptr.byt == LAST_REG);
        go       = retrig && eprom_mode;
        step_ok  = ((state == ST_STRB) && single) || ((state == ST_RET) && chain_ret);
    end

    always_comb begin
        nxt     = state;
        ptr_clr = 1'b0;
        ptr_adv = 1'b0;
        unique case (state)
            ST_BOOT: begin
                if (eprom_mode) begin
                    nxt     = ST_ADDR;
                    ptr_clr = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_IDLE, ST_DONE: begin
                if (go) begin
                    nxt     = ST_ADDR;
                    ptr_clr = 1'b1;
                end
            end
            ST_ADDR: begin
                if (wcnt == WAIT_END) nxt = ST_STRB;
            end
            ST_STRB: begin
                if (!single) nxt = ST_RET;
            end
            ST_RET: ;
            default: nxt = ST_IDLE;
        endcase
        if (step_ok) begin
            if (fin) begin
                nxt = ST_DONE;
            end else begin
                nxt     = ST_ADDR;
                ptr_adv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_BOOT;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || (state != ST_ADDR)) wcnt <= '0;
        else                           wcnt <= wcnt + WC_ONE;
    end

    assign strobe = (state == ST_STRB);
    assign load_n = !state_loading(state);
    assign done   = (state == ST_DONE);
    assign wr_en  = strobe && (ptr.blk == '0) && (ptr.byt <= LAST_REG);
endmodule

// File: rtl/boot_ldr_top.sv
module boot_ldr_top
    import ldr_pkg::*;
#(
    parameter int ROM_WAIT = 2,
    parameter int NUM_REGS = 74
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               eprom_mode_i,
    input  logic               single_i,
    input  logic               retrigger_i,
    input  logic               chain_ret_i,
    input  logic [DATA_W-1:0]  rom_data_i,
    output logic [BYTE_AW-1:0] rom_addr_o,
    output logic [BLK_W-1:0]   rom_blk_o,
    output logic               strobe_o,
    output logic               load_n_o,
    output logic               done_o,
    input  logic [BYTE_AW-1:0] cfg_raddr_i,
    output logic [DATA_W-1:0]  cfg_rdata_o
);
    rom_ptr_t         ptr;
    logic             ptr_clr, ptr_adv, wr_en;
    logic [BLK_W-1:0] dev_cnt;

    ldr_ptr_cnt u_ptr (
        .clk (clk),
        .rst (rst),
        .clr (ptr_clr),
        .adv (ptr_adv),
        .ptr (ptr)
    );

    ldr_seq #(
        .ROM_WAIT (ROM_WAIT),
        .NUM_REGS (NUM_REGS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .eprom_mode (eprom_mode_i),
        .single     (single_i),
        .retrig     (retrigger_i),
        .chain_ret  (chain_ret_i),
        .ptr        (ptr),
        .dev_cnt    (dev_cnt),
        .ptr_clr    (ptr_clr),
        .ptr_adv    (ptr_adv),
        .strobe     (strobe_o),
        .load_n     (load_n_o),
        .done       (done_o),
        .wr_en      (wr_en)
    );

    ldr_cfg_regs #(
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .widx    (ptr.byt),
        .wdata   (rom_data_i),
        .ridx    (cfg_raddr_i),
        .rdata   (cfg_rdata_o),
        .dev_cnt (dev_cnt)
    );

    assign rom_addr_o = ptr.byt;
    assign rom_blk_o  = ptr.blk;
endmodule

// File: rtl/ldr_chk.sv
module ldr_chk (
    input logic       clk,
    input logic       rst,
    input logic       single_i,
    input logic [6:0] rom_addr_o,
    input logic [3:0] rom_blk_o,
    input logic       strobe_o,
    input logic       load_n_o,
    input logic       done_o
);
    // R2: the strobe lasts a single cycle
    assert_strobe_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

    // R2: the address is already settled when the strobe appears
    assert_addr_settled_R2: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> ($stable(rom_addr_o) && $stable(rom_blk_o)));

    // R4: in a cascade the address is held past the strobe
    assert_ret_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && !single_i) |=> (rom_addr_o == $past(rom_addr_o)));

    // R1: no strobe outside a load
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
        load_n_o |-> !strobe_o);

    // R8: done and load in progress never overlap
    assert_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> load_n_o);

    // R5: a stand-alone device stays on block zero
    assert_single_blk_R5: assert property (@(posedge clk) disable iff (rst)
        (single_i && !load_n_o) |-> (rom_blk_o == 4'd0));
endmodule

bind boot_ldr_top ldr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .single_i   (single_i),
    .rom_addr_o (rom_addr_o),
    .rom_blk_o  (rom_blk_o),
    .strobe_o   (strobe_o),
    .load_n_o   (load_n_o),
    .done_o     (done_o)
);

// File: tb/boot_ldr_top_tb.sv
`timescale 1ns/1ps
module boot_ldr_top_tb;
    localparam int ROM_WAIT = 2;
    localparam int NUM_REGS = 74;
    localparam int P_BOOT = 0, P_IDLE = 1, P_ADDR = 2, P_STRB = 3, P_RET = 4, P_DONE = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, mode, single, retrig, ret;
    logic [7:0] cfg_byte;
    logic [7:0] rom_data;
    logic [6:0] rom_addr, raddr;
    logic [3:0] rom_blk;
    logic       strobe, load_n, done;
    logic [7:0] rdata;

    int vecs = 0, errs = 0;
    int m_ph, m_byte, m_blk, m_wc, cyc, ret_mode, strobes, max_blk;
    int m_mem[NUM_REGS];

    assign rom_data = (rom_blk == 4'd0 && rom_addr == 7'd0) ? cfg_byte
                    : 8'((int'(rom_blk) * 29 + int'(rom_addr) * 7 + 11));

    boot_ldr_top #(.ROM_WAIT(ROM_WAIT), .NUM_REGS(NUM_REGS)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .eprom_mode_i (mode),
        .single_i     (single),
        .retrigger_i  (retrig),
        .chain_ret_i  (ret),
        .rom_data_i   (rom_data),
        .rom_addr_o   (rom_addr),
        .rom_blk_o    (rom_blk),
        .strobe_o     (strobe),
        .load_n_o     (load_n),
        .done_o       (done),
        .cfg_raddr_i  (raddr),
        .cfg_rdata_o  (rdata)
    );

    function automatic int rom_fn(int b, int a);
        if (b == 0 && a == 0) return int'(cfg_byte);
        return (b * 29 + a * 7 + 11) % 256;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic m_start();
        m_byte = 0; m_blk = 0; m_wc = 0; m_ph = P_ADDR;
    endtask

    task automatic m_next();
        bit last;
        last = single || (m_blk == (m_mem[0] % 16));
        if (last && m_byte == NUM_REGS - 1) begin
            m_ph = P_DONE;
        end else begin
            if (m_byte == 127) begin m_byte = 0; m_blk++; end
            else m_byte++;
            m_wc = 0;
            m_ph = P_ADDR;
        end
    endtask

    task automatic model_adv();
        if (rst) begin
            m_ph = P_BOOT; m_byte = 0; m_blk = 0; m_wc = 0;
            foreach (m_mem[i]) m_mem[i] = 0;
            return;
        end
        case (m_ph)
            P_BOOT: if (mode) m_start(); else m_ph = P_IDLE;
            P_IDLE, P_DONE: if (retrig && mode) m_start();
            P_ADDR: if (m_wc == ROM_WAIT - 1) begin m_ph = P_STRB; m_wc = 0; end
                    else m_wc++;
            P_STRB: begin
                if (m_blk == 0 && m_byte < NUM_REGS) m_mem[m_byte] = rom_fn(0, m_byte);
                if (single) m_next(); else m_ph = P_RET;
            end
            P_RET: if (ret) m_next();
            default: ;
        endcase
    endtask

    task automatic step();
        case (ret_mode)
            1: ret = (cyc % 3 == 0);
            2: ret = (cyc % 4 == 1);
            default: ret = 1'b1;
        endcase
        model_adv();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        chk(rom_addr == 7'(m_byte), "R2 rom_addr", int'(rom_addr), m_byte);
        chk(rom_blk == 4'(m_blk), "R3 rom_blk", int'(rom_blk), m_blk);
        chk(strobe == (m_ph == P_STRB), "R4 strobe", int'(strobe), int'(m_ph == P_STRB));
        chk(load_n == !(m_ph >= P_ADDR && m_ph <= P_RET), "R6 load_n", int'(load_n),
            int'(!(m_ph >= P_ADDR && m_ph <= P_RET)));
        chk(done == (m_ph == P_DONE), "R8 done", int'(done), int'(m_ph == P_DONE));
        if (strobe) strobes++;
        if (!load_n && int'(rom_blk) > max_blk) max_blk = int'(rom_blk);
    endtask

    task automatic pulse_retrig();
        retrig = 1'b1; step(); retrig = 1'b0;
    endtask

    task automatic run_done(int lim);
        int n = 0;
        while (m_ph != P_DONE && n < lim) begin step(); n++; end
        chk(m_ph == P_DONE, "R8 load completes", m_ph, P_DONE);
        step(); step();
        chk(done == 1'b1, "R8 done held", int'(done), 1);
    endtask

    task automatic check_regs();
        for (int i = 0; i < 80; i++) begin
            int exp;
            raddr = 7'(i);
            #0.01;
            exp = (i < NUM_REGS) ? rom_fn(0, i) : 0;
            chk(int'(rdata) == exp, "R7 register file", int'(rdata), exp);
        end
    endtask

    task automatic load_checks(int last_blk);
        chk(strobes == last_blk * 128 + NUM_REGS, "R6 strobe count", strobes, last_blk * 128 + NUM_REGS);
        chk(max_blk == last_blk, "R5 last block", max_blk, last_blk);
        check_regs();
    endtask

    initial begin
        #(200000 * 8);
        errs++;
        $display("FAIL R8 watchdog: actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        rst = 1'b1; mode = 1'b1; single = 1'b1; retrig = 1'b0; ret = 1'b1;
        cfg_byte = 8'hA3; raddr = '0; ret_mode = 0; cyc = 0;
        m_ph = P_BOOT; m_byte = 0; m_blk = 0; m_wc = 0;
        foreach (m_mem[i]) m_mem[i] = 0;

        // R9: reset state
        step(); step(); step();
        chk(load_n == 1'b1 && strobe == 1'b0 && done == 1'b0, "R9 reset outputs",
            int'({load_n, strobe, done}), 4);
        chk(rom_addr == 7'd0 && rom_blk == 4'd0, "R9 reset address", int'(rom_addr), 0);

        // R1: automatic start, stand-alone, count field ignored (R5)
        rst = 1'b0; strobes = 0; max_blk = 0;
        step();
        chk(load_n == 1'b0, "R1 auto start", int'(load_n), 0);
        run_done(5000);
        load_checks(0);

        // cascade with two extra devices, slow return, restart during load ignored (R8)
        single = 1'b0; cfg_byte = 8'h52; ret_mode = 1; strobes = 0; max_blk = 0;
        pulse_retrig();
        for (int i = 0; i < 200; i++) step();
        pulse_retrig();
        chk(load_n == 1'b0, "R8 restart ignored mid-load", int'(load_n), 0);
        run_done(20000);
        load_checks(2);

        // R5: device count zero means one block
        cfg_byte = 8'h30; ret_mode = 2; strobes = 0; max_blk = 0;
        pulse_retrig();
        run_done(20000);
        load_checks(0);

        // R3: full sixteen blocks
        cfg_byte = 8'h0F; ret_mode = 0; strobes = 0; max_blk = 0;
        pulse_retrig();
        run_done(40000);
        load_checks(15);

        // R1: hosted mode stays idle, restart ignored
        mode = 1'b0; rst = 1'b1; step(); step(); rst = 1'b0;
        for (int i = 0; i < 30; i++) step();
        chk(load_n == 1'b1, "R1 host idle", int'(load_n), 1);
        pulse_retrig();
        for (int i = 0; i < 10; i++) step();
        chk(load_n == 1'b1 && done == 1'b0, "R1 host restart ignored", int'({load_n, done}), 2);

        // restart accepted once mode goes high
        mode = 1'b1; single = 1'b1; cfg_byte = 8'h11; strobes = 0; max_blk = 0;
        pulse_retrig();
        chk(load_n == 1'b0, "R8 restart accepted", int'(load_n), 0);
        run_done(5000);
        load_checks(0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule